// File: doc/BRIEF.md
# Flash Erase Suspend/Resume Controller

This block owns the control bits of a flash erase and drives a simple model of the erase sequencer. Software writes a three-bit control word that holds an erase-select bit, a high-voltage-enable bit and a suspend bit. Raising high-voltage-enable while erase-select is set and suspend is clear starts an erase. The sequencer then advances one step per clock, as long as high voltage stays on, until it has covered every step. The controller then raises a done flag.

Software can pause a running erase by setting the suspend bit. When done reads 1, the pause has taken effect. While paused, the array may be read without first dropping erase-select or high voltage. Reads that land in one of the blocks latched for erasure are flagged as carrying indeterminate data, and all other reads are flagged valid. Clearing the suspend bit resumes the erase, but only while high voltage is enabled. On resume, the sequencer restarts from the last checkpoint at or below the point where it stopped, so a suspended erase can take longer than one that runs straight through.

Top module: `erase_susp_ctrl`

## Requirements
- R1: After reset the control bits, done, busy, paused, the read flags and the progress count are all 0.
- R2: A write of the control word with bit0 (erase select) = 1, bit2 (high voltage) = 1 and bit1 (suspend) = 0, while idle and with high voltage previously off, makes busy 1, done 0 and progress 0 after that edge. Progress then rises by one each clock, and busy falls and done rises STEPS clocks after the start write.
- R3: A write with bit1 = 1 while running makes paused 1 and done 1 after that edge, and progress holds its value while paused.
- R4: A read (rd_en with a block index) returns rd_vld_o = 1 one clock later. rd_ok_o is 0 while running, 0 while paused if the block is in the latched erase mask, and 1 otherwise, including while paused with erase select and high voltage still set.
- R5: A write with bit1 = 0 is ignored for the suspend bit when the stored high-voltage bit is 0, so suspend and paused stay 1.
- R6: A write with bit1 = 0 while paused and the stored high-voltage bit is 1 resumes the erase. Busy becomes 1, done 0, and progress is rounded down to a multiple of CKPT.
- R7: After resuming from progress p, the erase runs STEPS minus (p rounded down to a multiple of CKPT) more clocks before done, so the total grows by p mod CKPT steps.
- R8: While running with the stored high-voltage bit 0, progress does not advance.
- R9: The erase block mask is captured from sel_blk at the start write, and later changes of sel_blk have no effect on read flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 3 | Control word: bit2 high voltage, bit1 suspend, bit0 erase select |
| sel_blk | input | NBLK | Blocks to erase, captured at start |
| rd_en | input | 1 | Array read request |
| rd_blk | input | BLK_W | Block index of the read |
| rd_vld_o | output | 1 | Read result flag valid, one clock after rd_en |
| rd_ok_o | output | 1 | Read data is defined |
| ers_o | output | 1 | Stored erase-select bit |
| hv_o | output | 1 | Stored high-voltage bit |
| susp_o | output | 1 | Stored suspend bit |
| busy_o | output | 1 | Erase sequencer running |
| paused_o | output | 1 | Erase suspended |
| done_o | output | 1 | Erase completed or suspend acknowledged |
| progress_o | output | PROG_W | Sequencer step count |

## Verification
The bench builds the block with STEPS = 16, CKPT = 4 and NBLK = 4, so a whole erase, with and without a pause, finishes within a few dozen clocks. Suspending at step 6, which is not a checkpoint, makes the rollback to 4 and the two extra steps visible in both the progress count and the measured run length. Four blocks allow the latched mask to differ from a later sel_blk value, so hits and misses can be told apart.

// File: rtl/esc_pkg.sv
package esc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2
  } esc_state_e;

  // Control word: bit2 high voltage, bit1 suspend, bit0 erase select
  typedef struct packed {
    logic hv;
    logic susp;
    logic ers;
  } esc_ctrl_t;

endpackage

// File: rtl/esc_ctrl_reg.sv
module esc_ctrl_reg
  import esc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  esc_ctrl_t wr_data,
  output esc_ctrl_t ctrl_q
);

  esc_ctrl_t ctrl_d;

  // Suspend may only drop while the stored high-voltage bit is on
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.ers  = wr_data.ers;
      ctrl_d.hv   = wr_data.hv;
      ctrl_d.susp = wr_data.susp | (ctrl_q.susp & ~ctrl_q.hv);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

endmodule

// File: rtl/esc_fsm.sv
module esc_fsm
  import esc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  esc_ctrl_t  wr_data,
  input  logic       hv_q,
  input  logic       last_step,
  output esc_state_e state_q,
  output logic       start_evt,
  output logic       susp_evt,
  output logic       resume_evt,
  output logic       step_en,
  output logic       done_q
);

  esc_state_e state_d;
  logic       done_d;
  logic       complete;

  always_comb begin
    start_evt  = wr_en && (state_q == ST_IDLE) && wr_data.ers && wr_data.hv
                 && !wr_data.susp && !hv_q;
    susp_evt   = wr_en && (state_q == ST_RUN) && wr_data.susp;
    resume_evt = wr_en && (state_q == ST_SUSP) && !wr_data.susp && hv_q;
    step_en    = (state_q == ST_RUN) && hv_q && !susp_evt;
    complete   = step_en && last_step;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_evt) state_d = ST_RUN;
      ST_RUN: begin
        if (susp_evt)      state_d = ST_SUSP;
        else if (complete) state_d = ST_IDLE;
      end
      ST_SUSP: if (resume_evt) state_d = ST_RUN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d = done_q;
    if (start_evt || resume_evt)  done_d = 1'b0;
    else if (susp_evt || complete) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

endmodule

// File: rtl/esc_progress.sv
module esc_progress #(
  parameter int STEPS  = 256,
  parameter int CKPT   = 8,
  localparam int PROG_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              resume_evt,
  input  logic              step_en,
  output logic [PROG_W-1:0] prog_q,
  output logic              last_step
);

  localparam logic [PROG_W-1:0] LAST_VAL = PROG_W'(STEPS - 1);

  logic [PROG_W-1:0] prog_d;
  logic [PROG_W-1:0] rb_val;
  logic              prog_en;

  generate
    if (CKPT > 1) begin : g_roll
      localparam logic [PROG_W-1:0] ROLL_MASK = ~PROG_W'(CKPT - 1);
      assign rb_val = prog_q & ROLL_MASK;
    end else begin : g_noroll
      assign rb_val = prog_q;
    end
  endgenerate

  assign last_step = (prog_q == LAST_VAL);

  always_comb begin
    prog_en = 1'b0;
    prog_d  = prog_q;
    if (start_evt) begin
      prog_en = 1'b1;
      prog_d  = '0;
    end else if (resume_evt) begin
      prog_en = 1'b1;
      prog_d  = rb_val;
    end else if (step_en && !last_step) begin
      prog_en = 1'b1;
      prog_d  = prog_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
    end else if (prog_en) begin
      prog_q <= prog_d;
    end
  end

endmodule

// File: rtl/esc_rd_guard.sv
module esc_rd_guard
  import esc_pkg::*;
#(
  parameter int NBLK  = 16,
  localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic [NBLK-1:0]  sel_blk,
  input  esc_state_e       state_q,
  input  logic             rd_en,
  input  logic [BLK_W-1:0] rd_blk,
  output logic             rd_vld_q,
  output logic             rd_ok_q
);

  logic [NBLK-1:0] mask_q;
  logic            hit;
  logic            ok_d;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NBLK; i++) begin
      if (rd_blk == BLK_W'(i)) hit = mask_q[i];
    end
  end

  always_comb begin
    unique case (state_q)
      ST_RUN:  ok_d = 1'b0;
      ST_SUSP: ok_d = !hit;
      default: ok_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (start_evt) begin
      mask_q <= sel_blk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q <= 1'b0;
      rd_ok_q  <= 1'b0;
    end else begin
      rd_vld_q <= rd_en;
      rd_ok_q  <= rd_en && ok_d;
    end
  end

endmodule

// File: rtl/erase_susp_ctrl.sv
module erase_susp_ctrl
  import esc_pkg::*;
#(
  parameter int  STEPS  = 256,
  parameter int  CKPT   = 8,
  parameter int  NBLK   = 16,
  localparam int PROG_W = $clog2(STEPS),
  localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_data,
  input  logic [NBLK-1:0]   sel_blk,
  input  logic              rd_en,
  input  logic [BLK_W-1:0]  rd_blk,
  output logic              rd_vld_o,
  output logic              rd_ok_o,
  output logic              ers_o,
  output logic              hv_o,
  output logic              susp_o,
  output logic              busy_o,
  output logic              paused_o,
  output logic              done_o,
  output logic [PROG_W-1:0] progress_o
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  esc_ctrl_t  wr_word;
  esc_ctrl_t  ctrl_q;
  esc_state_e state_q;
  logic       start_evt, susp_evt, resume_evt, step_en, last_step, done_q;
  logic [PROG_W-1:0] prog_q;

  assign wr_word = esc_ctrl_t'(wr_data);

  esc_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_word),
    .ctrl_q  (ctrl_q)
  );

  esc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_data    (wr_word),
    .hv_q       (ctrl_q.hv),
    .last_step  (last_step),
    .state_q    (state_q),
    .start_evt  (start_evt),
    .susp_evt   (susp_evt),
    .resume_evt (resume_evt),
    .step_en    (step_en),
    .done_q     (done_q)
  );

  esc_progress #(.STEPS(STEPS), .CKPT(CKPT)) u_prog (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_evt  (start_evt),
    .resume_evt (resume_evt),
    .step_en    (step_en),
    .prog_q     (prog_q),
    .last_step  (last_step)
  );

  esc_rd_guard #(.NBLK(NBLK)) u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_evt (start_evt),
    .sel_blk   (sel_blk),
    .state_q   (state_q),
    .rd_en     (rd_en),
    .rd_blk    (rd_blk),
    .rd_vld_q  (rd_vld_o),
    .rd_ok_q   (rd_ok_o)
  );

  assign ers_o      = ctrl_q.ers;
  assign hv_o       = ctrl_q.hv;
  assign susp_o     = ctrl_q.susp;
  assign busy_o     = (state_q == ST_RUN);
  assign paused_o   = (state_q == ST_SUSP);
  assign done_o     = done_q;
  assign progress_o = prog_q;

endmodule

// File: rtl/esc_chk.sv
module esc_chk #(
  parameter int  STEPS  = 256,
  parameter int  CKPT   = 8,
  localparam int PROG_W = $clog2(STEPS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_data,
  input logic              rd_en,
  input logic              rd_vld_o,
  input logic              rd_ok_o,
  input logic              hv_o,
  input logic              susp_o,
  input logic              busy_o,
  input logic              paused_o,
  input logic              done_o,
  input logic [PROG_W-1:0] progress_o
);

  localparam logic [PROG_W-1:0] RB_MASK = ~PROG_W'(CKPT - 1);

  a_r1_single_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, paused_o}));

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy_o && !paused_o && wr_data == 3'b101 && !hv_o)
    |=> (busy_o && !done_o && progress_o == '0));

  a_r3_susp_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy_o && wr_data[1]) |=> (paused_o && done_o));

  a_r3_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_o && $past(paused_o)) |-> $stable(progress_o));

  a_r4_run_reads_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy_o) |=> (rd_vld_o && !rd_ok_o));

  a_r4_idle_reads_good: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy_o && !paused_o) |=> (rd_vld_o && rd_ok_o));

  a_r5_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && susp_o && !hv_o) |=> susp_o);

  a_r6_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && paused_o && hv_o && !wr_data[1])
    |=> (busy_o && !done_o && progress_o == ($past(progress_o) & RB_MASK)));

  a_r8_hv_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !hv_o) |=> $stable(progress_o));

endmodule

bind erase_susp_ctrl esc_chk #(.STEPS(STEPS), .CKPT(CKPT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_vld_o   (rd_vld_o),
  .rd_ok_o    (rd_ok_o),
  .hv_o       (hv_o),
  .susp_o     (susp_o),
  .busy_o     (busy_o),
  .paused_o   (paused_o),
  .done_o     (done_o),
  .progress_o (progress_o)
);

// File: tb/erase_susp_ctrl_bench.sv
module erase_susp_ctrl_bench;

  localparam int STEPS = 16;
  localparam int CKPT  = 4;
  localparam int NBLK  = 4;
  localparam int PW    = $clog2(STEPS);
  localparam int BW    = $clog2(NBLK);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_data;
  logic [NBLK-1:0] sel_blk;
  logic          rd_en;
  logic [BW-1:0] rd_blk;
  logic          rd_vld_o, rd_ok_o, ers_o, hv_o, susp_o, busy_o, paused_o, done_o;
  logic [PW-1:0] progress_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  erase_susp_ctrl #(.STEPS(STEPS), .CKPT(CKPT), .NBLK(NBLK)) u_erase_susp_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .sel_blk(sel_blk),
    .rd_en(rd_en), .rd_blk(rd_blk), .rd_vld_o(rd_vld_o), .rd_ok_o(rd_ok_o),
    .ers_o(ers_o), .hv_o(hv_o), .susp_o(susp_o), .busy_o(busy_o),
    .paused_o(paused_o), .done_o(done_o), .progress_o(progress_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic wr(input logic [2:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int blk, input int exp_ok, input string req);
    rd_en = 1'b1; rd_blk = BW'(blk);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, "rd_vld", int'(rd_vld_o), 1);
    check(req, $sformatf("rd_ok blk%0d", blk), int'(rd_ok_o), exp_ok);
  endtask

  task automatic t_reset;
    check("R1", "busy", int'(busy_o), 0);
    check("R1", "paused", int'(paused_o), 0);
    check("R1", "done", int'(done_o), 0);
    check("R1", "progress", int'(progress_o), 0);
    check("R1", "ctrl bits", int'({hv_o, susp_o, ers_o}), 0);
    check("R1", "rd_vld", int'(rd_vld_o), 0);
  endtask

  task automatic t_full_erase;
    sel_blk = 4'b0001;
    wr(3'b101);
    check("R2", "busy after start", int'(busy_o), 1);
    check("R2", "done after start", int'(done_o), 0);
    check("R2", "progress after start", int'(progress_o), 0);
    repeat (STEPS - 1) @(negedge clk);
    check("R2", "progress at last step", int'(progress_o), STEPS - 1);
    check("R2", "busy before end", int'(busy_o), 1);
    @(negedge clk);
    check("R2", "busy at end", int'(busy_o), 0);
    check("R2", "done at end", int'(done_o), 1);
    rd(0, 1, "R4");
    wr(3'b000);
  endtask

  task automatic t_suspend_resume;
    int cnt;
    sel_blk = 4'b0110;
    wr(3'b101);
    sel_blk = 4'b1001;              // R9: change after start
    rd(0, 0, "R4");                 // running: invalid; progress 1
    repeat (5) @(negedge clk);
    check("R2", "progress before suspend", int'(progress_o), 6);
    wr(3'b111);
    check("R3", "paused", int'(paused_o), 1);
    check("R3", "done ack", int'(done_o), 1);
    check("R3", "progress frozen", int'(progress_o), 6);
    repeat (3) @(negedge clk);
    check("R3", "progress held", int'(progress_o), 6);
    check("R4", "ers/hv kept during reads", int'({hv_o, ers_o}), 3);
    rd(1, 0, "R4");
    rd(2, 0, "R9");                 // latched mask hit
    rd(0, 1, "R9");                 // new sel_blk ignored
    rd(3, 1, "R4");
    wr(3'b011);                     // high voltage off, suspend kept
    wr(3'b001);                     // clear attempt without high voltage
    check("R5", "susp stays", int'(susp_o), 1);
    check("R5", "paused stays", int'(paused_o), 1);
    check("R5", "progress", int'(progress_o), 6);
    wr(3'b111);
    wr(3'b101);                     // resume
    check("R6", "busy after resume", int'(busy_o), 1);
    check("R6", "done cleared", int'(done_o), 0);
    check("R6", "rollback", int'(progress_o), 4);
    cnt = 0;
    while (busy_o && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    check("R7", "clocks after resume", cnt, STEPS - 4);
    check("R7", "done after resume", int'(done_o), 1);
    wr(3'b000);
  endtask

  task automatic t_hv_hold;
    int p;
    sel_blk = 4'b0000;
    wr(3'b101);
    repeat (2) @(negedge clk);
    wr(3'b001);
    p = int'(progress_o);
    check("R8", "last step with old hv", p, 3);
    repeat (3) @(negedge clk);
    check("R8", "held with hv off", int'(progress_o), p);
    wr(3'b101);
    check("R8", "no step on hv write edge", int'(progress_o), p);
    @(negedge clk);
    check("R8", "steps again", int'(progress_o), p + 1);
    for (int i = 0; i < 40 && busy_o; i++) @(negedge clk);
    check("R2", "done after hold run", int'(done_o), 1);
    wr(3'b000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; sel_blk = '0; rd_en = 1'b0; rd_blk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_full_erase;
    t_suspend_resume;
    t_hv_hold;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule